// File: doc/BRIEF.md
# Single-Segment Memory/FIFO DMA Engine

This block is a one-segment DMA engine placed inside a storage host controller. It moves one contiguous buffer between system memory and the controller's data FIFOs. Software sets up a transfer through a small register window. It picks a direction, a beat width and an address mode, gives a 64-bit start address in two 32-bit halves, and gives a length in bytes. It then sets a start bit. The engine copies that setup into working registers and issues one memory beat per valid/ready handshake until the whole length has moved. It then pulses a completion strobe and sets a sticky status bit.

Each direction has its own channel, and each channel has an active-low reset bit. Software aborts a running transfer by clearing the bit of the active channel and later setting it again. While a channel's bit is clear, that channel also ignores start requests. A start that asks for an illegal setup raises a sticky error and moves no data. Illegal setups are an unknown direction, a zero length, or an address or length that is not a multiple of the beat size. On the FIFO side, a memory-to-device transfer pushes into the transmit FIFO and waits while that FIFO is full. A device-to-memory transfer pops the receive FIFO and waits while that FIFO is empty. Narrow beats use the low lanes of the data bus; no lane steering is done.

Top module: `seg_dma_engine`

## Requirements
- R1: After reset the engine is idle and every register reads zero, except the channel reset register (offset 0x418), which reads 0x300 (both channels released).
- R2: The mode register (offset 0x410) holds direction in bits [17:16] (0 = memory to device, 1 = device to memory, 2 and 3 invalid), the beat width code in bits [5:4] (0..3 = 1, 2, 4, 8 bytes), and address increment in bit 0. Only these bits read back; all others read zero.
- R3: Writing 1 to bit 0 of the control register (offset 0x414) makes that bit read 1 for exactly one cycle. In the next cycle it reads 0 again. When the start is accepted, `busy` rises in that same next cycle.
- R4: `memAddr` starts at {high word at 0x444, low word at 0x440}. It advances by the beat size on each accepted beat when increment is set, stays fixed when increment is clear, and holds its last value once the transfer ends.
- R5: A transfer issues exactly length/beat-size beats (length at offset 0x420), and `memSize` carries the width code.
- R6: In memory-to-device transfers `memWrite` is 0. Each handshake pushes `memRdData` into the transmit FIFO in the same cycle. `memValid` stays low while `txFull` is high.
- R7: In device-to-memory transfers `memWrite` is 1 and `memWrData` equals `rxData`. Each handshake pops the receive FIFO in the same cycle. `memValid` stays low while `rxEmpty` is high.
- R8: The cycle after the last handshake, `busy` is low and `xferDone` is high for exactly one cycle. The status register (offset 0x424; bit 0 busy, bit 1 done, bit 2 error) keeps the done bit until the next accepted start.
- R9: A start with an invalid direction, zero length, or an address or length not a multiple of the beat size sets the sticky error (`xferErr`, status bit 2) and issues no beat. An accepted start clears both the error and the done bits.
- R10: The channel reset register holds the memory-to-device channel in bit 8 and the device-to-memory channel in bit 9; 0 holds the channel in reset. Writing 0 to the active channel's bit during a transfer drops `memValid` in that write cycle. `busy` is low from the next cycle, and no done pulse follows. Clearing only the other channel's bit has no effect on the transfer.
- R11: A start whose direction's channel bit is 0 is ignored: no beat, no busy, no error. After the bit is set back to 1, a start works normally.
- R12: While busy, a further start request and new mode, address or length values have no effect on the running transfer.
- R13: `memValid` is never high while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| memValid | output | 1 | Memory beat request valid |
| memReady | input | 1 | Memory accepts the beat |
| memWrite | output | 1 | 1 = beat writes memory, 0 = beat reads memory |
| memAddr | output | 64 | Beat byte address |
| memSize | output | 2 | Beat width code |
| memWrData | output | DATA_W | Write data toward memory |
| memRdData | input | DATA_W | Read data from memory, valid on the handshake |
| txPush | output | 1 | Push into transmit FIFO |
| txData | output | DATA_W | Transmit FIFO write data |
| txFull | input | 1 | Transmit FIFO full |
| rxPop | output | 1 | Pop from receive FIFO |
| rxData | input | DATA_W | Receive FIFO head data |
| rxEmpty | input | 1 | Receive FIFO empty |
| busy | output | 1 | Transfer in progress |
| xferDone | output | 1 | One-cycle completion pulse |
| xferErr | output | 1 | Sticky setup error |

## Verification
The assertions check these rules on every cycle: no request while idle, the FIFO stall rules for each direction, a still address during a stalled beat, a done pulse that lasts one cycle and only while idle, the abort response, and errors that appear only while idle. Only the bench's scenarios can show the rest. That covers the exact beat count and end address for each width and address mode, the one-cycle start bit, and the sticky status across error, abort and success. It also covers the per-channel separation of aborts and held starts, and that setup writes made during a transfer have no effect. A cycle-by-cycle model in the bench follows every request, address, size and FIFO strobe through stalls from both the memory and FIFO sides.

// File: rtl/seg_dma_pkg.sv
package seg_dma_pkg;

  localparam int REG_AW  = 12;
  localparam int REG_DW  = 32;
  localparam int ADDR_W  = 64;
  localparam int LEN_W   = 32;
  localparam int NUM_CH  = 2;

  // Register offsets
  localparam logic [REG_AW-1:0] OFS_MODE   = 12'h410;
  localparam logic [REG_AW-1:0] OFS_CTL    = 12'h414;
  localparam logic [REG_AW-1:0] OFS_CHRST  = 12'h418;
  localparam logic [REG_AW-1:0] OFS_LEN    = 12'h420;
  localparam logic [REG_AW-1:0] OFS_STAT   = 12'h424;
  localparam logic [REG_AW-1:0] OFS_ADDRLO = 12'h440;
  localparam logic [REG_AW-1:0] OFS_ADDRHI = 12'h444;

  // Field positions
  localparam int MODE_DIR_LSB   = 16;
  localparam int MODE_WIDTH_LSB = 4;
  localparam int MODE_INC_BIT   = 0;
  localparam int CTL_START_BIT  = 0;
  localparam int CHRST_LSB      = 8;
  localparam int STAT_BUSY_BIT  = 0;
  localparam int STAT_DONE_BIT  = 1;
  localparam int STAT_ERR_BIT   = 2;

  typedef enum logic {ST_IDLE, ST_RUN} dmaState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;   // capture the programmed setup into working registers
    logic issue;  // running and not being aborted this cycle
  } dpCmd_t;

  function automatic logic [2:0] alignMask(input logic [1:0] widthCode);
    case (widthCode)
      2'd0:    alignMask = 3'b000;
      2'd1:    alignMask = 3'b001;
      2'd2:    alignMask = 3'b011;
      default: alignMask = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/seg_dma_regs.sv
module seg_dma_regs
  import seg_dma_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [REG_DW-1:0]    regWrData,
  output logic [REG_DW-1:0]    regRdData,
  input  logic                 startClr,
  input  logic                 busy,
  input  logic                 doneSticky,
  input  logic                 errSticky,
  output logic [1:0]           cfgDir,
  output logic [1:0]           cfgWidth,
  output logic                 cfgInc,
  output logic [LEN_W-1:0]     cfgLen,
  output logic [ADDR_W-1:0]    cfgAddr,
  output logic [NUM_CH-1:0]    chanRun,
  output logic                 startReq,
  output logic                 rstWr,
  output logic [NUM_CH-1:0]    rstWrVal
);

  logic modeSel, ctlSel, lenSel, loSel, hiSel;
  logic startQ;

  always_comb begin
    modeSel  = regWrEn && (regAddr == OFS_MODE);
    ctlSel   = regWrEn && (regAddr == OFS_CTL);
    rstWr    = regWrEn && (regAddr == OFS_CHRST);
    lenSel   = regWrEn && (regAddr == OFS_LEN);
    loSel    = regWrEn && (regAddr == OFS_ADDRLO);
    hiSel    = regWrEn && (regAddr == OFS_ADDRHI);
    rstWrVal = regWrData[CHRST_LSB +: NUM_CH];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDir   <= '0;
      cfgWidth <= '0;
      cfgInc   <= 1'b0;
    end else if (modeSel) begin
      cfgDir   <= regWrData[MODE_DIR_LSB +: 2];
      cfgWidth <= regWrData[MODE_WIDTH_LSB +: 2];
      cfgInc   <= regWrData[MODE_INC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgLen <= '0;
    else if (lenSel) cfgLen <= regWrData[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgAddr <= '0;
    else begin
      if (loSel) cfgAddr[31:0]  <= regWrData;
      if (hiSel) cfgAddr[63:32] <= regWrData;
    end
  end

  // Self-clearing start bit: a new write wins over the clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startQ <= 1'b0;
    else if (ctlSel && regWrData[CTL_START_BIT]) startQ <= 1'b1;
    else if (startClr) startQ <= 1'b0;
  end
  assign startReq = startQ;

  // One active-low hold bit per channel, released at reset.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic runQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) runQ <= 1'b1;
      else if (rstWr) runQ <= rstWrVal[ch];
    end
    assign chanRun[ch] = runQ;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_MODE: begin
        regRdData[MODE_DIR_LSB +: 2]   = cfgDir;
        regRdData[MODE_WIDTH_LSB +: 2] = cfgWidth;
        regRdData[MODE_INC_BIT]        = cfgInc;
      end
      OFS_CTL:    regRdData[CTL_START_BIT] = startQ;
      OFS_CHRST:  regRdData[CHRST_LSB +: NUM_CH] = chanRun;
      OFS_LEN:    regRdData = cfgLen;
      OFS_STAT: begin
        regRdData[STAT_BUSY_BIT] = busy;
        regRdData[STAT_DONE_BIT] = doneSticky;
        regRdData[STAT_ERR_BIT]  = errSticky;
      end
      OFS_ADDRLO: regRdData = cfgAddr[31:0];
      OFS_ADDRHI: regRdData = cfgAddr[63:32];
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/seg_dma_ctrl.sv
module seg_dma_ctrl
  import seg_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [1:0]        cfgDir,
  input  logic [NUM_CH-1:0] chanRun,
  input  logic              cfgBad,
  input  logic              rstWr,
  input  logic [NUM_CH-1:0] rstWrVal,
  input  logic              runDir,
  input  logic              beatFire,
  input  logic              lastBeat,
  output dpCmd_t            cmd,
  output logic              busy,
  output logic              startClr,
  output logic              xferDone,
  output logic              doneSticky,
  output logic              errSticky
);

  dmaState_t state;
  logic accept, held, errSet, abortNow, lastFire;

  always_comb begin
    accept    = (state == ST_IDLE) && startReq;
    held      = !chanRun[cfgDir[0]];
    abortNow  = (state == ST_RUN) && rstWr && !rstWrVal[runDir];
    cmd.load  = accept && !cfgDir[1] && !held && !cfgBad;
    cmd.issue = (state == ST_RUN) && !abortNow;
    errSet    = accept && (cfgDir[1] || (!held && cfgBad));
    lastFire  = (state == ST_RUN) && beatFire && lastBeat;
    busy      = (state == ST_RUN);
    startClr  = startReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else if (cmd.load) state <= ST_RUN;
    else if (abortNow || lastFire) state <= ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferDone   <= 1'b0;
      doneSticky <= 1'b0;
      errSticky  <= 1'b0;
    end else begin
      xferDone <= lastFire;
      if (cmd.load) begin
        doneSticky <= 1'b0;
        errSticky  <= 1'b0;
      end else begin
        if (lastFire) doneSticky <= 1'b1;
        if (errSet)   errSticky  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/seg_dma_datapath.sv
module seg_dma_datapath
  import seg_dma_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [1:0]        cfgDir,
  input  logic [1:0]        cfgWidth,
  input  logic              cfgInc,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              txFull,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxEmpty,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWrData,
  output logic              txPush,
  output logic [DATA_W-1:0] txData,
  output logic              rxPop,
  output logic              beatFire,
  output logic              lastBeat,
  output logic              cfgBad,
  output logic              runDir
);

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remBeats;
  logic [1:0]        wWidth;
  logic              wInc;
  logic              wDir;
  logic              fifoOk;
  logic [2:0]        progMask;
  logic [ADDR_W-1:0] stride;

  always_comb begin
    progMask = alignMask(cfgWidth);
    cfgBad   = cfgDir[1] || (cfgLen == '0) ||
               ((cfgAddr[2:0] & progMask) != 3'b000) ||
               ((cfgLen[2:0] & progMask) != 3'b000);
  end

  always_comb begin
    stride    = wInc ? (ADDR_W'(1) << wWidth) : '0;
    fifoOk    = wDir ? !rxEmpty : !txFull;
    memValid  = cmd.issue && fifoOk;
    beatFire  = memValid && memReady;
    lastBeat  = (remBeats == LEN_W'(1));
    memWrite  = wDir;
    memAddr   = curAddr;
    memSize   = wWidth;
    memWrData = rxData;
    txData    = memRdData;
    txPush    = beatFire && !wDir;
    rxPop     = beatFire && wDir;
    runDir    = wDir;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remBeats <= '0;
      wWidth   <= '0;
      wInc     <= 1'b0;
      wDir     <= 1'b0;
    end else if (cmd.load) begin
      curAddr  <= cfgAddr;
      remBeats <= cfgLen >> cfgWidth;
      wWidth   <= cfgWidth;
      wInc     <= cfgInc;
      wDir     <= cfgDir[0];
    end else if (beatFire) begin
      curAddr  <= curAddr + stride;
      remBeats <= remBeats - LEN_W'(1);
    end
  end

endmodule

// File: rtl/seg_dma_engine.sv
module seg_dma_engine
  import seg_dma_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [63:0]       memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              txPush,
  output logic [DATA_W-1:0] txData,
  input  logic              txFull,
  output logic              rxPop,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxEmpty,
  output logic              busy,
  output logic              xferDone,
  output logic              xferErr
);

  dpCmd_t            cmd;
  logic [1:0]        cfgDir, cfgWidth;
  logic              cfgInc, cfgBad;
  logic [LEN_W-1:0]  cfgLen;
  logic [ADDR_W-1:0] cfgAddr;
  logic [NUM_CH-1:0] chanRun, rstWrVal;
  logic              startReq, startClr, rstWr;
  logic              beatFire, lastBeat, runDir;
  logic              doneSticky, errSticky;

  seg_dma_regs u_regs (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .startClr(startClr), .busy(busy), .doneSticky(doneSticky), .errSticky(errSticky),
    .cfgDir(cfgDir), .cfgWidth(cfgWidth), .cfgInc(cfgInc), .cfgLen(cfgLen), .cfgAddr(cfgAddr),
    .chanRun(chanRun), .startReq(startReq), .rstWr(rstWr), .rstWrVal(rstWrVal)
  );

  seg_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(startReq), .cfgDir(cfgDir), .chanRun(chanRun), .cfgBad(cfgBad),
    .rstWr(rstWr), .rstWrVal(rstWrVal), .runDir(runDir),
    .beatFire(beatFire), .lastBeat(lastBeat),
    .cmd(cmd), .busy(busy), .startClr(startClr),
    .xferDone(xferDone), .doneSticky(doneSticky), .errSticky(errSticky)
  );

  seg_dma_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .cfgDir(cfgDir), .cfgWidth(cfgWidth), .cfgInc(cfgInc), .cfgLen(cfgLen), .cfgAddr(cfgAddr),
    .memReady(memReady), .memRdData(memRdData), .txFull(txFull), .rxData(rxData), .rxEmpty(rxEmpty),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr), .memSize(memSize),
    .memWrData(memWrData), .txPush(txPush), .txData(txData), .rxPop(rxPop),
    .beatFire(beatFire), .lastBeat(lastBeat), .cfgBad(cfgBad), .runDir(runDir)
  );

  assign xferErr = errSticky;

endmodule

// File: rtl/seg_dma_checker.sv
module seg_dma_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [11:0] regAddr,
  input logic [31:0] regWrData,
  input logic        memValid,
  input logic        memReady,
  input logic        memWrite,
  input logic [63:0] memAddr,
  input logic        txFull,
  input logic        rxEmpty,
  input logic        busy,
  input logic        xferDone,
  input logic        xferErr
);

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memValid);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> !busy);

  // R6
  tx_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite) |-> !txFull);

  // R7
  rx_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |-> !rxEmpty);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(memValid && memReady)) |=> $stable(memAddr));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && (regAddr == 12'h418) && (regWrData[9:8] == 2'b00)) |=> (!busy && !xferDone));

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferErr) |-> !busy);

endmodule

bind seg_dma_engine seg_dma_checker u_seg_dma_checker (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .memValid(memValid), .memReady(memReady), .memWrite(memWrite), .memAddr(memAddr),
  .txFull(txFull), .rxEmpty(rxEmpty), .busy(busy), .xferDone(xferDone), .xferErr(xferErr)
);

// File: tb/seg_dma_engine_bench.sv
module seg_dma_engine_bench;

  localparam int DW = 64;
  localparam logic [11:0] A_MODE = 12'h410, A_CTL = 12'h414, A_RST = 12'h418,
                          A_LEN = 12'h420, A_STAT = 12'h424, A_LO = 12'h440, A_HI = 12'h444;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic memValid, memWrite, txPush, rxPop, busy, xferDone, xferErr;
  logic memReady = 1'b0;
  logic [63:0] memAddr;
  logic [1:0] memSize;
  logic [DW-1:0] memWrData, txData;
  logic [DW-1:0] memRdData = '0;
  logic [DW-1:0] rxData = '0;
  logic txFull = 1'b0;
  logic rxEmpty = 1'b0;

  always #10 clk = ~clk;

  seg_dma_engine #(.DATA_W(DW)) u_seg_dma_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .memValid(memValid), .memReady(memReady), .memWrite(memWrite),
    .memAddr(memAddr), .memSize(memSize), .memWrData(memWrData), .memRdData(memRdData),
    .txPush(txPush), .txData(txData), .txFull(txFull), .rxPop(rxPop), .rxData(rxData),
    .rxEmpty(rxEmpty), .busy(busy), .xferDone(xferDone), .xferErr(xferErr)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int fireCnt = 0;
  bit readyMode = 1'b0;
  bit fifoStall = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishSim();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [1:0]  rDir = '0, rWidth = '0;
  bit          rInc = 0;
  logic [31:0] rLen = '0;
  logic [63:0] rAddr = '0;
  logic [1:0]  rRst = 2'b11;
  bit          mStartPend = 0, mBusy = 0, mDoneP = 0, mDoneS = 0, mErrS = 0;
  bit          mDir = 0, mInc = 0;
  logic [1:0]  mWidth = '0;
  logic [63:0] mAddr = '0;
  longint      mRem = 0;

  function automatic longint unsigned nb(input logic [1:0] w);
    return longint'(1) << w;
  endfunction

  function automatic bit abortWr();
    return regWrEn && (regAddr == A_RST) && !regWrData[8 + int'(mDir)];
  endfunction

  function automatic bit expValid();
    return mBusy && !abortWr() && (mDir ? !rxEmpty : !txFull);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      rDir = '0; rWidth = '0; rInc = 0; rLen = '0; rAddr = '0; rRst = 2'b11;
      mStartPend = 0; mBusy = 0; mDoneP = 0; mDoneS = 0; mErrS = 0;
      mDir = 0; mInc = 0; mWidth = '0; mAddr = '0; mRem = 0;
    end else begin
      bit fire, ab, nd;
      fire = expValid() && memReady;
      ab = mBusy && abortWr();
      nd = 0;
      if (mBusy) begin
        if (ab) mBusy = 0;
        else if (fire) begin
          if (mInc) mAddr = mAddr + nb(mWidth);
          mRem--;
          if (mRem == 0) begin mBusy = 0; nd = 1; mDoneS = 1; end
        end
      end else if (mStartPend) begin
        if (rDir > 2'd1) mErrS = 1;
        else if (!rRst[rDir[0]]) begin end
        else if (rLen == 0 || (rAddr % nb(rWidth)) != 0 || (64'(rLen) % nb(rWidth)) != 0) mErrS = 1;
        else begin
          mBusy = 1; mDir = rDir[0]; mWidth = rWidth; mInc = rInc; mAddr = rAddr;
          mRem = longint'(64'(rLen) / nb(rWidth)); mDoneS = 0; mErrS = 0;
        end
      end
      mStartPend = 0;
      if (regWrEn) begin
        case (regAddr)
          A_MODE: begin rDir = regWrData[17:16]; rWidth = regWrData[5:4]; rInc = regWrData[0]; end
          A_CTL:  if (regWrData[0]) mStartPend = 1;
          A_RST:  rRst = regWrData[9:8];
          A_LEN:  rLen = regWrData;
          A_LO:   rAddr[31:0] = regWrData;
          A_HI:   rAddr[63:32] = regWrData;
          default: begin end
        endcase
      end
      mDoneP = nd;
    end
  end

  // ---------------- stimulus for memory and FIFO sides ----------------
  always @(negedge clk) begin
    memReady  = readyMode ? ((cyc % 3) != 0) : 1'b1;
    txFull    = fifoStall && ((cyc % 5) == 2);
    rxEmpty   = fifoStall && ((cyc % 4) == 1);
    memRdData = {32'hA5A5_0000 ^ 32'(cyc), 32'(cyc * 3)};
    rxData    = {32'(cyc), ~32'(cyc)};
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    #5;
    if (rstN && !finished) begin
      bit ev;
      ev = expValid();
      chk(busy == mBusy, "R3 busy", 64'(busy), 64'(mBusy));
      chk(xferDone == mDoneP, "R8 xferDone", 64'(xferDone), 64'(mDoneP));
      chk(xferErr == mErrS, "R9 xferErr", 64'(xferErr), 64'(mErrS));
      chk(memValid == ev, "R13 memValid", 64'(memValid), 64'(ev));
      if (ev) begin
        chk(memAddr == mAddr, "R4 memAddr", memAddr, mAddr);
        chk(memSize == mWidth, "R5 memSize", 64'(memSize), 64'(mWidth));
        chk(memWrite == mDir, "R6 memWrite", 64'(memWrite), 64'(mDir));
        if (mDir) chk(memWrData == rxData, "R7 memWrData", memWrData, rxData);
      end
      chk(txPush == (ev && memReady && !mDir), "R6 txPush", 64'(txPush), 64'(ev && memReady && !mDir));
      chk(rxPop == (ev && memReady && mDir), "R7 rxPop", 64'(rxPop), 64'(ev && memReady && mDir));
      if (txPush) chk(txData == memRdData, "R6 txData", txData, memRdData);
      if (memValid && memReady) fireCnt++;
    end
  end

  // ---------------- tasks ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #3;
    chk(regRdData == exp, tag, 64'(regRdData), 64'(exp));
  endtask

  task automatic prog(input logic [1:0] d, input logic [1:0] w, input bit inc,
                      input logic [63:0] a, input logic [31:0] len);
    wr(A_MODE, (32'(d) << 16) | (32'(w) << 4) | 32'(inc));
    wr(A_LO, a[31:0]);
    wr(A_HI, a[63:32]);
    wr(A_LEN, len);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!mBusy && !mStartPend) break;
    end
    @(negedge clk);
  endtask

  task automatic runXfer(input logic [1:0] d, input logic [1:0] w, input bit inc,
                         input logic [63:0] a, input logic [31:0] len, input string tag);
    prog(d, w, inc, a, len);
    fireCnt = 0;
    wr(A_CTL, 32'h1);
    waitIdle();
    chk(fireCnt == int'(len >> w), {tag, " R5 beat count"}, 64'(fireCnt), 64'(len >> w));
    chk(memAddr == (inc ? a + 64'(len) : a), {tag, " R4 end address"}, memAddr, inc ? a + 64'(len) : a);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finishSim();
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk(A_MODE, 32'h0, "R1 mode");
    rdChk(A_CTL,  32'h0, "R1 ctl");
    rdChk(A_RST,  32'h300, "R1 chrst");
    rdChk(A_LEN,  32'h0, "R1 len");
    rdChk(A_STAT, 32'h0, "R1 status");
    rdChk(A_LO,   32'h0, "R1 addrlo");
    rdChk(A_HI,   32'h0, "R1 addrhi");
    chk(!busy && !memValid, "R1 idle", 64'({busy, memValid}), 64'h0);

    // R2 R3 R6: memory to device, 64-bit, incrementing, with stalls
    readyMode = 1; fifoStall = 1;
    prog(2'd0, 2'd3, 1'b1, 64'h0000_0001_0000_0100, 32'd32);
    @(negedge clk);
    rdChk(A_MODE, 32'h0000_0031, "R2 mode readback");
    rdChk(A_HI, 32'h1, "R4 addrhi readback");
    fireCnt = 0;
    wr(A_CTL, 32'h1);
    rdChk(A_CTL, 32'h1, "R3 start reads one");
    chk(!busy, "R3 busy not yet", 64'(busy), 64'h0);
    @(negedge clk);
    rdChk(A_CTL, 32'h0, "R3 start self-cleared");
    chk(busy, "R3 busy raised", 64'(busy), 64'h1);
    waitIdle();
    chk(fireCnt == 4, "R5 beats 64-bit", 64'(fireCnt), 64'd4);
    chk(memAddr == 64'h0000_0001_0000_0120, "R4 increment end", memAddr, 64'h0000_0001_0000_0120);
    rdChk(A_STAT, 32'h2, "R8 done sticky");

    // R7 device to memory, 8-bit, fixed address
    runXfer(2'd1, 2'd0, 1'b0, 64'h7777, 32'd5, "R7 d2m byte fixed");
    rdChk(A_STAT, 32'h2, "R8 done after d2m");

    // other widths
    runXfer(2'd1, 2'd1, 1'b1, 64'h2002, 32'd6, "R7 d2m half");
    readyMode = 0; fifoStall = 0;
    runXfer(2'd0, 2'd2, 1'b1, 64'h3004, 32'd12, "R6 m2d word");

    // R9 errors
    fireCnt = 0;
    prog(2'd0, 2'd2, 1'b1, 64'h102, 32'd8);
    wr(A_CTL, 32'h1);
    repeat (3) @(negedge clk);
    chk(xferErr && !busy, "R9 misaligned addr", 64'({xferErr, busy}), 64'h2);
    rdChk(A_STAT, 32'h6, "R9 status err+done");
    prog(2'd0, 2'd3, 1'b1, 64'h40, 32'd12);
    wr(A_CTL, 32'h1);
    repeat (3) @(negedge clk);
    prog(2'd0, 2'd0, 1'b1, 64'h40, 32'd0);
    wr(A_CTL, 32'h1);
    repeat (3) @(negedge clk);
    wr(A_MODE, 32'hFFFF_FFFF);
    @(negedge clk);
    rdChk(A_MODE, 32'h0003_0031, "R2 unused bits read zero");
    wr(A_LO, 32'h0); wr(A_LEN, 32'd16);
    wr(A_CTL, 32'h1);
    repeat (3) @(negedge clk);
    chk(fireCnt == 0, "R9 no beats on error", 64'(fireCnt), 64'h0);
    rdChk(A_STAT, 32'h6, "R9 invalid direction");
    runXfer(2'd0, 2'd0, 1'b1, 64'h50, 32'd3, "R9 recovery");
    rdChk(A_STAT, 32'h2, "R9 error cleared by start");

    // R10 abort of memory-to-device channel
    readyMode = 1;
    prog(2'd0, 2'd3, 1'b1, 64'h8000, 32'd64);
    fireCnt = 0;
    wr(A_CTL, 32'h1);
    for (int i = 0; i < 200 && fireCnt < 3; i++) @(negedge clk);
    wr(A_RST, 32'h200);
    chk(!busy, "R10 busy dropped", 64'(busy), 64'h0);
    repeat (4) @(negedge clk);
    chk(fireCnt < 8, "R10 transfer cut short", 64'(fireCnt), 64'd7);
    rdChk(A_RST, 32'h200, "R10 reset readback");
    rdChk(A_STAT, 32'h0, "R10 no done after abort");

    // R11 start on held channel ignored
    fireCnt = 0;
    wr(A_CTL, 32'h1);
    repeat (5) @(negedge clk);
    chk(fireCnt == 0 && !busy, "R11 held start ignored", 64'(fireCnt), 64'h0);
    rdChk(A_STAT, 32'h0, "R11 no error on held start");
    // R10 other channel still runs
    runXfer(2'd1, 2'd3, 1'b1, 64'hA000, 32'd16, "R10 d2m channel unaffected");
    wr(A_RST, 32'h300);
    runXfer(2'd0, 2'd3, 1'b1, 64'hB000, 32'd24, "R11 released channel runs");

    // R10 clearing only the idle channel's bit during a transfer
    prog(2'd0, 2'd2, 1'b1, 64'hC000, 32'd40);
    fireCnt = 0;
    wr(A_CTL, 32'h1);
    @(negedge clk);
    wr(A_RST, 32'h100);
    waitIdle();
    chk(fireCnt == 10, "R10 other channel reset ignored", 64'(fireCnt), 64'd10);
    wr(A_RST, 32'h300);

    // R12 reprogramming while busy
    prog(2'd0, 2'd2, 1'b1, 64'h4000, 32'd80);
    fireCnt = 0;
    wr(A_CTL, 32'h1);
    for (int i = 0; i < 200 && fireCnt < 2; i++) @(negedge clk);
    wr(A_MODE, 32'h0001_0000);
    wr(A_LO, 32'h9000);
    wr(A_LEN, 32'd4);
    wr(A_CTL, 32'h1);
    chk(busy, "R12 still busy after writes", 64'(busy), 64'h1);
    waitIdle();
    chk(fireCnt == 20, "R12 beat count unchanged", 64'(fireCnt), 64'd20);
    chk(memAddr == 64'h4050, "R12 address unchanged", memAddr, 64'h4050);

    repeat (3) @(negedge clk);
    finishSim();
  end

endmodule